// File: doc/BRIEF.md
# Tap-Difference Timing Loop Controller

This block closes the timing loop of a receiver in which an adaptive fractionally spaced equalizer and a resampler work together. The timing error is not taken from signal samples. It comes from the equalizer's own weights. When the sampling instant drifts, the energy in the equalizer's impulse response moves to one side of the center tap. Once per equalizer output symbol, after that symbol's weight update, the block takes the tap just ahead of the center and subtracts the tap just behind it. A larger tap behind the center means the sampling is late, and the result is negative. A larger tap ahead of the center means the sampling is early, and the result is positive. The size of the difference sets the size of the correction. The detector is a single subtraction and uses no multiplier.

The raw error goes through a proportional-integral loop filter. Both gains are powers of two, set as right-shift parameters, and together they set the loop's noise bandwidth. The filter output is a signed control word for the resampler's numerically controlled oscillator. The integrator and the control word both saturate and never wrap. A freeze input holds the whole filter state. It is used, for example, while the equalizer is still converging.

Top module: `tap_timing_loop`

## Requirements
- R1: After reset, `ctrl_word` is 0 and the integrator holds 0, so a strobe carrying equal taps leaves `ctrl_word` at 0.
- R2: The timing error is `tap_pre - tap_post`, computed at TAP_W+1 bits so that it never wraps. With the defaults, 2047 - (-2048) gives +4095.
- R3: Early sampling (`tap_pre > tap_post`) moves `ctrl_word` upward from zero. Late sampling (`tap_post > tap_pre`) moves it downward.
- R4: The correction grows with the size of the tap difference. For an error e, the proportional term is e arithmetically shifted right by KP_SH, and the integral step is e arithmetically shifted right by KI_SH. Both shifts round toward negative infinity. The defaults are KP_SH=2 and KI_SH=6.
- R5: Each unfrozen strobe adds the integral step to the integrator. The integrator saturates at -2^(INT_W-1) and at 2^(INT_W-1)-1.
- R6: `ctrl_word` equals the updated integrator plus the proportional term, saturated to CW_W signed bits. It updates on the clock edge that follows the edge where `sym_vld` is sampled high, and it changes at no other time.
- R7: Without `sym_vld`, `ctrl_word` and the integrator hold their values.
- R8: A strobe that arrives with `freeze` high leaves both the integrator and `ctrl_word` unchanged.
- R9: The loop-filter gains and the integrator and control-word widths are parameters. With the defaults, `ctrl_word` saturates at +32767 and at -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sym_vld | input | 1 | One-cycle strobe: the taps belong to a fresh, updated symbol |
| freeze | input | 1 | Sampled together with `sym_vld`; high holds the filter state |
| tap_pre | input | TAP_W | Signed weight of the tap just ahead of the center |
| tap_post | input | TAP_W | Signed weight of the tap just behind the center |
| ctrl_word | output | CW_W | Signed control word for the resampler oscillator |

## Verification
A wrong integrator value cannot be seen directly. It appears in `ctrl_word` one clock after the next strobe. A strobe with equal taps carries zero error, so `ctrl_word` then equals the integrator exactly. The bench uses such strobes after its long drive toward each limit, to show saturation without wrap. A wrong sign or a wrong shift shows in the first strobe after reset, because the expected values are rebuilt from the shift and saturation rules alone. Wrong handling of freeze or idle cycles shows as a change in `ctrl_word` where none may occur.

// File: rtl/tap_timing_pkg.sv
package tap_timing_pkg;

    // All filter arithmetic is done at this width; INT_W and CW_W must stay below it.
    localparam int ARITH_W = 32;

    typedef logic signed [ARITH_W-1:0] arith_t;

    // Clamp a wide value into [lo, hi].
    function automatic arith_t clip(input arith_t v, input arith_t lo, input arith_t hi);
        arith_t r;
        if (v > hi)      r = hi;
        else if (v < lo) r = lo;
        else             r = v;
        return r;
    endfunction

    // Smallest and largest values of a signed field that is w bits wide.
    function automatic arith_t smin(input int w);
        return -(arith_t'(1) <<< (w - 1));
    endfunction

    function automatic arith_t smax(input int w);
        return (arith_t'(1) <<< (w - 1)) - arith_t'(1);
    endfunction

endpackage

// File: rtl/tdiff_detector.sv
module tdiff_detector #(
    parameter int TAP_W = 12,
    localparam int ERR_W = TAP_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sym_vld,
    input  logic                    freeze,
    input  logic signed [TAP_W-1:0] tap_pre,
    input  logic signed [TAP_W-1:0] tap_post,
    output logic                    err_vld,
    output logic                    err_hold,
    output logic signed [ERR_W-1:0] err
);

    typedef struct packed {
        logic                    vld;
        logic                    hold;
        logic signed [ERR_W-1:0] err;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = sym_vld;
        if (sym_vld) begin
            st_d.hold = freeze;
            // Widened by one bit so the full span of the difference fits.
            st_d.err  = {tap_pre[TAP_W-1], tap_pre} - {tap_post[TAP_W-1], tap_post};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_vld  = st_q.vld;
    assign err_hold = st_q.hold;
    assign err      = st_q.err;

    // The registered error is the tap difference captured with the strobe.
    p_err_diff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |=> (err == ($past({tap_pre[TAP_W-1], tap_pre}) - $past({tap_post[TAP_W-1], tap_post}))));

    // The error valid flag is a single-cycle echo of the strobe.
    p_vld_echo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld |=> !err_vld);

endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
    import tap_timing_pkg::*;
#(
    parameter int ERR_W = 13,
    parameter int KP_SH = 2,
    parameter int KI_SH = 6,
    parameter int INT_W = 16,
    parameter int CW_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    err_vld,
    input  logic                    err_hold,
    input  logic signed [ERR_W-1:0] err,
    output logic signed [CW_W-1:0]  ctrl
);

    localparam arith_t INT_MIN = smin(INT_W);
    localparam arith_t INT_MAX = smax(INT_W);
    localparam arith_t CW_MIN  = smin(CW_W);
    localparam arith_t CW_MAX  = smax(CW_W);

    typedef struct packed {
        logic signed [INT_W-1:0] integ;
        logic signed [CW_W-1:0]  ctrl;
    } lf_t;

    lf_t    st_d, st_q;
    arith_t e_w, i_step, p_term, i_sum, i_new, c_sum;

    always_comb begin
        st_d   = st_q;
        e_w    = arith_t'(err);
        i_step = e_w >>> KI_SH;
        p_term = e_w >>> KP_SH;
        i_sum  = arith_t'(st_q.integ) + i_step;
        i_new  = clip(i_sum, INT_MIN, INT_MAX);
        c_sum  = i_new + p_term;
        if (err_vld && !err_hold) begin
            st_d.integ = INT_W'(i_new);
            st_d.ctrl  = CW_W'(clip(c_sum, CW_MIN, CW_MAX));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;

    // With no error pending, the filter state holds.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vld |=> ($stable(st_q.integ) && $stable(ctrl)));

    // A frozen error leaves the state untouched.
    p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && err_hold) |=> ($stable(st_q.integ) && $stable(ctrl)));

    // A positive error never moves the integrator down.
    p_integ_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && !err_hold && (err > 0)) |=> (st_q.integ >= $past(st_q.integ)));

    // A negative error never moves the integrator up.
    p_integ_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && !err_hold && (err < 0)) |=> (st_q.integ <= $past(st_q.integ)));

endmodule

// File: rtl/tap_timing_loop.sv
module tap_timing_loop #(
    parameter int TAP_W = 12,
    parameter int KP_SH = 2,
    parameter int KI_SH = 6,
    parameter int INT_W = 16,
    parameter int CW_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sym_vld,
    input  logic                    freeze,
    input  logic signed [TAP_W-1:0] tap_pre,
    input  logic signed [TAP_W-1:0] tap_post,
    output logic signed [CW_W-1:0]  ctrl_word
);

    localparam int ERR_W = TAP_W + 1;

    logic                    err_vld;
    logic                    err_hold;
    logic signed [ERR_W-1:0] err;

    tdiff_detector #(.TAP_W(TAP_W)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_vld  (sym_vld),
        .freeze   (freeze),
        .tap_pre  (tap_pre),
        .tap_post (tap_post),
        .err_vld  (err_vld),
        .err_hold (err_hold),
        .err      (err)
    );

    pi_loop_filter #(
        .ERR_W (ERR_W),
        .KP_SH (KP_SH),
        .KI_SH (KI_SH),
        .INT_W (INT_W),
        .CW_W  (CW_W)
    ) u_lf (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_vld  (err_vld),
        .err_hold (err_hold),
        .err      (err),
        .ctrl     (ctrl_word)
    );

    // The control word moves only two edges after a strobe is seen.
    p_ctrl_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_word) |-> $past(sym_vld, 2));

endmodule

// File: tb/tap_timing_loop_tb.sv
module tap_timing_loop_tb;

    localparam int TAP_W = 12;
    localparam int NV    = 10;

    // Stimulus table: pre tap, post tap, freeze.
    localparam int VPRE [NV] = '{ 2047,  100, -300,  400,  800,    0, 1500,  -7,   5,  -2048};
    localparam int VPOST[NV] = '{-2048,    0,  500,  400,    0,  800,    0,   9,   5,   2047};
    localparam bit VFRZ [NV] = '{    0,    0,    0,    0,    0,    0,    1,   0,   0,      0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_vld = 1'b0;
    logic freeze = 1'b0;
    logic signed [TAP_W-1:0] tap_pre = '0;
    logic signed [TAP_W-1:0] tap_post = '0;
    logic signed [15:0] ctrl_word;

    int n_chk = 0;
    int n_bad = 0;
    int m_int = 0;
    int m_ctrl = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tap_timing_loop u_dut (
        .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .freeze(freeze),
        .tap_pre(tap_pre), .tap_post(tap_post), .ctrl_word(ctrl_word)
    );

    function automatic int sat(input int v, input int lo, input int hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    // Requirement model: error, shifts and saturation.
    task automatic model(input int pre, input int post, input bit frz);
        int e;
        e = pre - post;
        if (!frz) begin
            m_int  = sat(m_int + (e >>> 6), -32768, 32767);
            m_ctrl = sat(m_int + (e >>> 2), -32768, 32767);
        end
    endtask

    task automatic check(input string req, input int exp);
        n_chk++;
        if (int'(ctrl_word) != exp) begin
            n_bad++;
            $display("FAIL %s: ctrl_word actual %0d expected %0d", req, ctrl_word, exp);
        end
    endtask

    // One strobe; returns at the negedge after ctrl_word has updated.
    task automatic strobe(input int pre, input int post, input bit frz);
        @(negedge clk);
        tap_pre  = TAP_W'(pre);
        tap_post = TAP_W'(post);
        freeze   = frz;
        sym_vld  = 1'b1;
        @(negedge clk);
        sym_vld  = 1'b0;
        freeze   = 1'b0;
        @(negedge clk);
        model(pre, post, frz);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_int = 0;
        m_ctrl = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 0);                 // reset value
        rst_n = 1'b1;
        @(negedge clk);
        strobe(0, 0, 0);
        check("R1", 0);                 // equal taps after reset: integrator at zero

        do_reset();
        // Table walk: R2 full-width error, R3 sign, R4 magnitude, R8 freeze.
        for (int i = 0; i < NV; i++) begin
            strobe(VPRE[i], VPOST[i], VFRZ[i]);
            check(VFRZ[i] ? "R8" : "R4", m_ctrl);
            if (i == 0) check("R2", 1086);  // 4095>>>6 + 4095>>>2
        end

        // R3: sign from reset.
        do_reset();
        strobe(300, 100, 0);
        n_chk++;
        if (!(ctrl_word > 0)) begin n_bad++; $display("FAIL R3: early actual %0d expected >0", ctrl_word); end
        do_reset();
        strobe(100, 300, 0);
        n_chk++;
        if (!(ctrl_word < 0)) begin n_bad++; $display("FAIL R3: late actual %0d expected <0", ctrl_word); end

        // R7: idle cycles hold the output.
        begin
            int held;
            held = int'(ctrl_word);
            repeat (6) @(negedge clk);
            check("R7", held);
        end

        // R8: a frozen strobe leaves the state alone; a zero-error strobe shows the integrator.
        strobe(2000, -2000, 1);
        check("R8", m_ctrl);
        strobe(0, 0, 0);
        check("R8", m_int);

        // R5 and R9: drive to the upper limit.
        do_reset();
        for (int k = 0; k < 600; k++) strobe(2047, -2048, 0);
        check("R9", 32767);
        strobe(0, 0, 0);
        check("R5", 32767);
        // Lower limit.
        for (int k = 0; k < 1100; k++) strobe(-2048, 2047, 0);
        check("R9", -32768);
        strobe(0, 0, 0);
        check("R5", -32768);
        // Back off the lower limit by one integral step (R6 sum).
        strobe(400, 0, 0);
        check("R6", m_ctrl);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule